// File: doc/BRIEF.md
# Two-Bank Memory-Mapped Interrupt Controller

This block gathers 64 interrupt inputs into two banks of 32 lines and exposes each bank through four 32-bit registers on a simple register bus. Every input first passes a synchronizer. On lines that are enabled, a rising edge is caught in a per-line event flag. A fixed parameter mask marks some lines as level-sensitive. Those lines also request service for as long as their input stays high. Software reads the live input state, sets the enable mask, and clears caught events by writing ones to an acknowledge register.

The block drives one interrupt request output and one vector output. The vector gives the highest-numbered pending line. All lines of the upper bank rank above all lines of the lower bank. Software uses the vector to pick the line it serves next, acknowledges it, and reads the vector again.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every enable bit and every event bit reads 0, `irq_req` is 0 and `irq_vec` is 0.
- R2: A rising edge on an input whose enable bit is 1 sets that line's bit in its bank's event register. Bit i of a bank register is line i of that bank for the lower bank, and line 32+i for the upper bank.
- R3: A rising edge on a disabled line is not latched. Setting an enable bit while the input is already high sets no event and raises no request on an edge-type line.
- R4: A write to the ack register clears the event bits written as 1. Bits written as 0 leave their events unchanged.
- R5: The level register reads the synchronized live input state. Writes to the level register and to the event register have no effect.
- R6: A line is pending when (event OR (input AND level mask)) AND enable. The default level mask is 0x3ff00000 for the lower bank and 0 for the upper bank. A level line that is enabled and held high requests service even after its event is acknowledged.
- R7: `irq_req` is 1 exactly when some line is pending. `irq_vec` bit 6 is a valid flag equal to `irq_req`. Bits 5:0 hold the line number.
- R8: When several lines are pending, `irq_vec` reports the highest-numbered one, so lines 32–63 always win over lines 0–31.
- R9: Register map, using a byte address: lines 0–31 sit at 0x20, lines 32–63 sit at 0x10. Within each bank, event is at +0x0, enable at +0x4, ack at +0x8 and level at +0xC. The ack register reads 0. Any other address reads 0 and ignores writes. Read data appears one cycle after `bus_rd`.
- R10: An event caught while the line was enabled stays latched after the line is disabled, and raises no request while disabled. Enabling the line again raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; bit i is the bank's line i |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| irq_lines | input | 64 | Asynchronous interrupt inputs |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 7 | Valid flag in bit 6, highest pending line in bits 5:0 |

## Verification
On every cycle, the assertions check three things. An event never appears on a line that was disabled. An acknowledged event is gone in the next cycle unless a new edge arrived at the same time. The encoder's choice is a pending line with no pending line above it.

Only the bench's scenarios can show the following:
- the register address map;
- that enabling a line whose input is already high stays silent;
- the level-mask merge after an acknowledge;
- that latched events survive disabling;
- that the upper bank wins over the lower bank.

// File: rtl/bic_pkg.sv
package bic_pkg;
  localparam int BANK_W = 32;
  localparam int NBANK  = 2;
  localparam int NLINES = BANK_W * NBANK;
  localparam int IDX_W  = $clog2(NLINES);
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } reg_sel_e;

  // value of address bits [5:4] that selects a bank's register window
  function automatic logic [1:0] bank_window(input int b);
    return (b == 0) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bic_bank.sv
module bic_bank #(
  parameter int          LINES      = 32,
  parameter logic [31:0] LEVEL_MASK = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl,
  input  logic             en_we,
  input  logic             ack_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] ev_q,
  output logic [LINES-1:0] en_q,
  output logic [LINES-1:0] pend
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] set_bits;
  logic [LINES-1:0] ack_bits;

  assign set_bits = lvl & ~prev_q & en_q;
  assign ack_bits = ack_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      en_q   <= '0;
      ev_q   <= '0;
    end else begin
      prev_q <= lvl;
      if (en_we) en_q <= wdata;
      // a fresh edge wins over a simultaneous acknowledge
      ev_q <= (ev_q & ~ack_bits) | set_bits;
    end
  end

  assign pend = (ev_q | (lvl & LEVEL_MASK[LINES-1:0])) & en_q;

  // R3: an event only appears on a line that was enabled
  assert_no_set_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(en_q)) == '0));

  // R4: acknowledged bits are cleared unless a new edge arrived with the ack
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((ev_q & $past(ack_bits & ~(lvl & ~prev_q))) == '0));
endmodule

// File: rtl/bic_prio.sv
module bic_prio #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end

  // R8: chosen line is pending and no higher line is pending
  assert_top_choice_R8: assert property (@(posedge clk) disable iff (rst)
    found |-> ((pend >> idx) == N'(1)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import bic_pkg::*;
#(
  parameter logic [31:0] LVL_MASK_LO = 32'h3ff0_0000,
  parameter logic [31:0] LVL_MASK_HI = 32'h0000_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BANK_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BANK_W-1:0] bus_rdata,
  input  logic [NLINES-1:0] irq_lines,
  output logic              irq_req,
  output logic [IDX_W:0]    irq_vec
);
  logic [NLINES-1:0] lvl_s;
  logic [NLINES-1:0] pend_all;
  logic [BANK_W-1:0] ev_b  [NBANK];
  logic [BANK_W-1:0] en_b  [NBANK];
  logic [NBANK-1:0]  hit;
  reg_sel_e          sel;
  logic              found;
  logic [IDX_W-1:0]  idx;
  logic [BANK_W-1:0] rd_mux;

  assign sel = reg_sel_e'(bus_addr[3:2]);

  bic_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(irq_lines), .q(lvl_s)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [31:0] MASK = (b == 0) ? LVL_MASK_LO : LVL_MASK_HI;
    assign hit[b] = (bus_addr[5:4] == bank_window(b));
    bic_bank #(.LINES(BANK_W), .LEVEL_MASK(MASK)) bank_i (
      .clk   (clk),
      .rst   (rst),
      .lvl   (lvl_s[b*BANK_W +: BANK_W]),
      .en_we (bus_wr && hit[b] && sel == REG_ENABLE),
      .ack_we(bus_wr && hit[b] && sel == REG_ACK),
      .wdata (bus_wdata),
      .ev_q  (ev_b[b]),
      .en_q  (en_b[b]),
      .pend  (pend_all[b*BANK_W +: BANK_W])
    );
  end

  bic_prio #(.N(NLINES), .W(IDX_W)) prio_i (
    .clk(clk), .rst(rst), .pend(pend_all), .found(found), .idx(idx)
  );

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit[b]) begin
        case (sel)
          REG_EVENT:  rd_mux = ev_b[b];
          REG_ENABLE: rd_mux = en_b[b];
          REG_LEVEL:  rd_mux = lvl_s[b*BANK_W +: BANK_W];
          default:    rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
      irq_vec   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_req <= found;
      irq_vec <= found ? {1'b1, idx} : '0;
    end
  end

  // R7: valid flag of the vector tracks the request output
  assert_vec_valid_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req == irq_vec[IDX_W]);

  // R7: an idle vector carries no line number
  assert_idle_vec_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0));
endmodule

// File: tb/banked_irq_ctrl_tb_top.sv
module banked_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_lines = '0;
  logic        irq_req;
  logic [6:0]  irq_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  localparam logic [5:0] LO_EV = 6'h20, LO_EN = 6'h24, LO_ACK = 6'h28, LO_LVL = 6'h2C;
  localparam logic [5:0] HI_EV = 6'h10, HI_EN = 6'h14, HI_ACK = 6'h18, HI_LVL = 6'h1C;

  typedef struct packed {
    logic [63:0] inp;
    logic [31:0] en_lo;
    logic [31:0] en_hi;
    logic [6:0]  vec;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{64'h0000_0000_0000_0008, 32'h0000_0008, 32'h0,          7'h43},
    '{64'h0000_0000_0000_0028, 32'hFFFF_FFFF, 32'h0,          7'h45},
    '{64'h0000_0100_0000_0020, 32'hFFFF_FFFF, 32'hFFFF_FFFF,  7'h68},
    '{64'h0000_0100_0000_0004, 32'hFFFF_FFFF, 32'h0,          7'h42},
    '{64'h0000_0000_0200_0000, 32'h0200_0000, 32'h0,          7'h59},
    '{64'h8000_0000_0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF,  7'h7F},
    '{64'h0000_0000_0000_0080, 32'h0,         32'h0,          7'h00},
    '{64'h0000_0001_0000_0000, 32'h0,         32'h0000_0001,  7'h60}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_req", irq_req, 0);
    check("R1 irq_vec", irq_vec, 0);
    rd(LO_EN, d); check("R1 enable lo", d, 0);
    rd(HI_EN, d); check("R1 enable hi", d, 0);
    rd(LO_EV, d); check("R1 event lo", d, 0);

    // Table walk: R2 R6 R7 R8
    foreach (TABLE[k]) begin
      irq_lines = '0;
      wr(LO_EN, 32'h0); wr(HI_EN, 32'h0);
      settle();
      wr(LO_ACK, 32'hFFFF_FFFF); wr(HI_ACK, 32'hFFFF_FFFF);
      wr(LO_EN, TABLE[k].en_lo); wr(HI_EN, TABLE[k].en_hi);
      irq_lines = TABLE[k].inp;
      settle();
      check($sformatf("R8 table entry %0d vec", k), irq_vec, TABLE[k].vec);
      check($sformatf("R7 table entry %0d req", k), irq_req, TABLE[k].vec[6]);
    end
    irq_lines = '0;
    wr(LO_EN, 0); wr(HI_EN, 0);
    settle();
    wr(LO_ACK, 32'hFFFF_FFFF); wr(HI_ACK, 32'hFFFF_FFFF);

    // R3 edge on disabled line, then enable while high
    irq_lines[4] = 1'b1;
    settle();
    rd(LO_EV, d); check("R3 no event when disabled", d, 0);
    rd(LO_LVL, d); check("R5 level shows input", d, 32'h10);
    wr(LO_EN, 32'h10);
    settle();
    check("R3 no req on enable-while-high", irq_req, 0);
    rd(LO_EV, d); check("R3 no event on enable-while-high", d, 0);

    // R2 fresh edge while enabled
    irq_lines[4] = 1'b0; settle();
    irq_lines[4] = 1'b1; settle();
    rd(LO_EV, d); check("R2 event latched", d, 32'h10);
    check("R7 vec line 4", irq_vec, 7'h44);

    // R4 zero bits of ack are ignored, one bits clear
    wr(LO_ACK, 32'hFFFF_FFEF);
    rd(LO_EV, d); check("R4 zero ack bit keeps event", d, 32'h10);
    wr(LO_ACK, 32'h10);
    settle();
    rd(LO_EV, d); check("R4 ack clears event", d, 0);
    check("R4 req drops after ack", irq_req, 0);
    irq_lines[4] = 1'b0;

    // R10 latched event survives disable
    wr(LO_EN, 32'h200);
    irq_lines[9] = 1'b1; settle();
    irq_lines[9] = 1'b0;
    wr(LO_EN, 32'h0); settle();
    rd(LO_EV, d); check("R10 event kept when disabled", d, 32'h200);
    check("R10 no req while disabled", irq_req, 0);
    wr(LO_EN, 32'h200); settle();
    check("R10 req after re-enable", irq_vec, 7'h49);
    wr(LO_ACK, 32'h200); wr(LO_EN, 0);

    // R6 level line requests without an event and after ack
    irq_lines[22] = 1'b1; settle();
    wr(LO_EN, 32'h0040_0000); settle();
    rd(LO_EV, d); check("R6 no event on level enable", d, 0);
    check("R6 level line pending", irq_vec, 7'h56);
    wr(LO_ACK, 32'hFFFF_FFFF); settle();
    check("R6 level persists after ack", irq_req, 1);
    irq_lines[22] = 1'b0; settle();
    check("R6 level drops with input", irq_req, 0);
    wr(LO_EN, 0);

    // R9 / R5 address map and ignored writes
    wr(HI_EN, 32'h0000_00A5);
    rd(HI_EN, d); check("R9 upper enable at 0x14", d, 32'hA5);
    rd(LO_EN, d); check("R9 lower enable separate", d, 0);
    rd(6'h00, d); check("R9 unmapped 0x00 reads 0", d, 0);
    rd(6'h34, d); check("R9 unmapped 0x34 reads 0", d, 0);
    rd(HI_ACK, d); check("R9 ack reads 0", d, 0);
    wr(LO_EV, 32'hFFFF_FFFF);
    rd(LO_EV, d); check("R5 event write ignored", d, 0);
    wr(HI_LVL, 32'hFFFF_FFFF);
    rd(HI_LVL, d); check("R5 level write ignored", d, 0);
    irq_lines[37] = 1'b1; settle();
    rd(HI_LVL, d); check("R9 upper level bit 5", d, 32'h20);
    rd(HI_EV, d); check("R9 upper event line 37", d, 32'h20);
    check("R8 upper line vec", irq_vec, 7'h65);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule